// File: doc/BRIEF.md
# I2C Serial Clock Generator with Independent Low and High Phases

This block makes the serial clock for an I2C master from a much faster input clock. The LOW and HIGH halves of each SCL period are timed separately, so software can stretch the LOW half to meet the bus minimum-low time without wasting time in the HIGH half. A fixed divide-by-8 prescaler produces a phase tick. Each phase then lasts a programmed number of ticks plus one. A value of zero is legal and gives the shortest phase, one tick long.

Inside every LOW phase the block raises a one-cycle strobe exactly halfway through. The byte engine upstream uses it to change SDA, so the data hold time is about half the LOW time. A second one-cycle pulse marks the last input cycle of every complete period. The sequencer uses it to step to the next bit.

The two divider inputs are copied into shadow registers when the block is enabled and at the end of each full period. Writes made in the middle of a period therefore never cut a phase short. While the block is disabled, SCL rests HIGH and every counter is held at zero.

Top module: `scl_asym_clkgen`

## Requirements
- R1: While reset is asserted, and while `en_i` is low after reset, `scl_o` is 1 and both `sda_upd_o` and `period_end_o` are 0.
- R2: If `en_i` is sampled high at a clock edge while the block is idle, `scl_o` is 0 from that edge on, so the first phase is always LOW.
- R3: Each LOW phase lasts exactly 8 × (L + 1) input cycles, where L is the shadowed low divider.
- R4: Each HIGH phase lasts exactly 8 × (H + 1) input cycles, where H is the shadowed high divider.
- R5: `period_end_o` is high for exactly one cycle: the last HIGH cycle of each period. The next cycle begins a new LOW phase, so a period spans 8 × (L + H + 2) cycles.
- R6: `sda_upd_o` pulses once per LOW phase, on the cycle whose zero-based offset from the start of LOW equals 4 × (L + 1).
- R7: Divider values are captured only on the enabling edge and on the edge that ends a period. A change made in mid-period first shows up in the next period.
- R8: When `en_i` is sampled low, `scl_o` reads 1 from the next cycle on and no strobes or period pulses appear. Divider changes made while disabled have no effect until re-enable, and re-enabling starts a fresh LOW phase from a zeroed prescaler.
- R9: Divider values 0 (an 8-cycle phase) and 2^DIV_W − 1 (a phase of 8 × 2^DIV_W cycles) both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the clock generator; low returns it to idle |
| div_low_i | input | DIV_W | LOW phase length in ticks, minus one |
| div_high_i | input | DIV_W | HIGH phase length in ticks, minus one |
| scl_o | output | 1 | SCL drive level (1 = released/high) |
| sda_upd_o | output | 1 | One-cycle strobe at the middle of LOW |
| period_end_o | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
The embedded assertions check these properties on every cycle:
- The block goes idle after a disable.
- Every enable starts with a LOW phase.
- Shadow dividers stay stable inside a period.
- The phase counter stays within its limit.
- Strobes appear only while SCL is low, and period pulses only while it is high.

Exact phase lengths, the cycle chosen for the mid-LOW strobe, the point where a new divider takes effect, and the extreme divider values can only be shown by the bench. Its scoreboard compares the cycle number of every SCL edge and every pulse against a schedule computed from the requirements.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  localparam logic [PRE_W-1:0] LAST = '1;

  logic [PRE_W-1:0] cnt_q;

  // Free-running while the generator runs; held at zero while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  AST_IDLE_CLEARS_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_low_i,
  input  logic [DIV_W-1:0] div_high_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] pre_cnt_i,
  output logic             run_o,
  output logic             scl_o,
  output logic             mid_low_o,
  output logic             period_end_o
);
  localparam int EW = DIV_W + PRE_W;

  // Offset of the mid-LOW cycle: half of 2^PRE_W * (n + 1).
  function automatic logic [EW-1:0] mid_offset(input logic [DIV_W-1:0] n);
    logic [EW-1:0] t;
    t = EW'(n) + EW'(1);
    return t << (PRE_W - 1);
  endfunction

  phase_e           phase_q;
  logic [DIV_W-1:0] ph_cnt_q;
  logic [DIV_W-1:0] sh_low_q;
  logic [DIV_W-1:0] sh_high_q;

  logic             low_done;
  logic             high_done;
  logic [EW-1:0]    low_elapsed;

  assign low_done    = (phase_q == PH_LOW)  && tick_i && (ph_cnt_q == sh_low_q);
  assign high_done   = (phase_q == PH_HIGH) && tick_i && (ph_cnt_q == sh_high_q);
  assign low_elapsed = {ph_cnt_q, pre_cnt_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ph_cnt_q  <= '0;
      sh_low_q  <= '0;
      sh_high_q <= '0;
    end else if (!en_i) begin
      phase_q  <= PH_IDLE;
      ph_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q   <= PH_LOW;
          ph_cnt_q  <= '0;
          sh_low_q  <= div_low_i;
          sh_high_q <= div_high_i;
        end
        PH_LOW: begin
          if (low_done) begin
            phase_q  <= PH_HIGH;
            ph_cnt_q <= '0;
          end else if (tick_i) begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (high_done) begin
            phase_q   <= PH_LOW;
            ph_cnt_q  <= '0;
            sh_low_q  <= div_low_i;
            sh_high_q <= div_high_i;
          end else if (tick_i) begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q  <= PH_IDLE;
          ph_cnt_q <= '0;
        end
      endcase
    end
  end

  assign run_o        = (phase_q != PH_IDLE);
  assign scl_o        = (phase_q != PH_LOW);
  assign mid_low_o    = (phase_q == PH_LOW) && (low_elapsed == mid_offset(sh_low_q));
  assign period_end_o = high_done;

  AST_FIRST_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && en_i) |=> !scl_o); // R2
  AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (ph_cnt_q <= sh_low_q)); // R3
  AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (ph_cnt_q <= sh_high_q)); // R4
  AST_PEND_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |-> scl_o); // R5
  AST_PEND_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end_o && en_i) |=> !scl_o); // R5
  AST_STROBE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low_o |-> !scl_o); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !period_end_o) |=> ($stable(sh_low_q) && $stable(sh_high_q))); // R7
  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (scl_o && !mid_low_o && !period_end_o)); // R8
endmodule

// File: rtl/scl_asym_clkgen.sv
module scl_asym_clkgen #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_low_i,
  input  logic [DIV_W-1:0] div_high_i,
  output logic             scl_o,
  output logic             sda_upd_o,
  output logic             period_end_o
);
  logic             run;
  logic             tick;
  logic [PRE_W-1:0] pre_cnt;

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick),
    .cnt_o  (pre_cnt)
  );

  scl_phase_ctrl #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .div_low_i    (div_low_i),
    .div_high_i   (div_high_i),
    .tick_i       (tick),
    .pre_cnt_i    (pre_cnt),
    .run_o        (run),
    .scl_o        (scl_o),
    .mid_low_o    (sda_upd_o),
    .period_end_o (period_end_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (scl_o && !sda_upd_o && !period_end_o)); // R1
endmodule

// File: tb/sim_scl_asym_clkgen.sv
module sim_scl_asym_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER      = 32'h7fff_ffff;

  typedef struct {
    int    kind;   // 0 fall, 1 rise, 2 strobe, 3 period end
    int    cyc;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] dlow = '0;
  logic [7:0] dhigh = '0;
  logic       scl, upd, pend;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  prev_scl = 1'b1;
  ev_t q[$];

  scl_asym_clkgen #(.DIV_W(8), .PRE_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .div_low_i(dlow), .div_high_i(dhigh),
    .scl_o(scl), .sda_upd_o(upd), .period_end_o(pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_ev(input int kind, input int c, input string req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    q.push_back(e);
  endtask

  // Driver: expected events of one period starting at 'start', those before 'limit'.
  task automatic plan_period(input int start, input int l, input int h,
                             input int limit, input string tag);
    int t_low;
    int t_high;
    t_low  = 8 * (l + 1);
    t_high = 8 * (h + 1);
    if (start < limit)                    push_ev(0, start, tag);
    if (start + 4*(l+1) < limit)          push_ev(2, start + 4*(l+1), "R6");
    if (start + t_low < limit)            push_ev(1, start + t_low, "R3");
    if (start + t_low + t_high - 1 < limit) push_ev(3, start + t_low + t_high - 1, "R4 R5");
  endtask

  task automatic check_val(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp_v);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: detect events and compare against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      kind = -1;
      if (prev_scl && !scl)      kind = 0;
      else if (!prev_scl && scl) kind = 1;
      else if (upd)              kind = 2;
      else if (pend)             kind = 3;
      if (kind >= 0) begin
        checks++;
        if (q.size() == 0) begin
          failures++;
          $display("FAIL R5 unexpected event: actual kind=%0d at %0d expected none", kind, cyc);
        end else begin
          ev_t e;
          e = q.pop_front();
          if (e.kind != kind || e.cyc != cyc) begin
            failures++;
            $display("FAIL %s: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                     e.req, kind, cyc, e.kind, e.cyc);
          end
        end
      end
      prev_scl = scl;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p;
    int s4;
    int p2;
    int s5;
    repeat (3) @(negedge clk);
    check_val("R1", int'(scl), 1);
    check_val("R1", int'(upd | pend), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_val("R1", int'(scl), 1);
    check_val("R1", int'(upd | pend), 0);

    // Zero dividers, then a mid-period change, then disable in mid-LOW.
    dlow = 8'd0; dhigh = 8'd0; en = 1'b1;
    p  = cyc + 1;
    s4 = p + 32 + 72 + 72;
    plan_period(p,       0, 0, NEVER, "R2");
    plan_period(p + 16,  0, 0, NEVER, "R9");
    plan_period(p + 32,  5, 2, NEVER, "R7");
    plan_period(p + 104, 5, 2, NEVER, "R5");
    plan_period(s4,      5, 2, s4 + 11, "R5");
    push_ev(1, s4 + 11, "R8");
    wait_until(p + 20);
    dlow = 8'd5; dhigh = 8'd2;       // lands in mid-period (R7)
    wait_until(s4 + 10);
    en = 1'b0;

    // Disabled: divider writes ignored, SCL stays high.
    wait_until(s4 + 15);
    dlow = 8'd1; dhigh = 8'd3;
    repeat (20) @(negedge clk);
    check_val("R8", int'(scl), 1);
    check_val("R8", int'(upd | pend), 0);

    // Re-enable with fresh values, then extreme dividers.
    en = 1'b1;
    p2 = cyc + 1;
    s5 = p2 + 96 + 4096;
    plan_period(p2,      1, 3, NEVER, "R8");
    plan_period(p2 + 48, 1, 3, NEVER, "R5");
    plan_period(p2 + 96, 255, 255, NEVER, "R9");
    plan_period(s5,      255, 255, s5 + 4, "R9");
    push_ev(1, s5 + 4, "R8");
    wait_until(p2 + 60);
    dlow = 8'd255; dhigh = 8'd255;
    wait_until(s5 + 3);
    en = 1'b0;
    repeat (20) @(negedge clk);
    check_val("R8", int'(scl), 1);
    check_val("R5", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule